// File: doc/BRIEF.md
# Accumulator Load, Alignment and Saturation Stage

This block is the write-back end of a fixed-point multiply-accumulate datapath. It owns two 36-bit accumulators, a 32-bit multiplier input register pair (`y` high and low halves) with its companion `x` register, and a 9-bit control register. A 32-bit product is sign-extended and shifted by a selectable amount. The result is optionally clamped to the signed 32-bit range and then written into one accumulator. Each accumulator can also be loaded through its upper half only. A control bit per destination decides whether the lower 16 bits are zeroed or kept on such a load.

Each accumulator write refreshes four condition flags: negative, zero, logical overflow and arithmetic overflow. It can also set a sticky overflow bit for the accumulator written. The flags, both sticky bits and the four guard bits of each accumulator are read back as one 16-bit status word. Writing the status word clears the sticky bits. All state changes happen on the rising clock edge and are visible one cycle after the request.

Top module: `dau_acc_unit`

## Requirements
- R1: The control register holds 9 bits and clears to zero at reset. A write stores `ctl_wdata[8:0]`, and `ctl_rdata[15:9]` always reads zero. Bit use is: [1:0] shift mode, [2] acc0 clamp off, [3] acc1 clamp off, [4] acc0 low-keep, [5] acc1 low-keep, [6] y low-keep, [7] square mode, [8] stored only.
- R2: On a product load the product is sign-extended, then the shift mode picks the result: 00 = unchanged, 01 = arithmetic shift right by 2, 10 = shift left by 2 with zeros in, 11 = shift left by 1 with a zero in.
- R3: A shifted result overflows when its bits 35:31 are not all equal. With the destination's clamp-off bit at 0, an overflowing load writes 36'h0_7FFF_FFFF for a non-negative product and 36'hF_8000_0000 for a negative one. With the bit at 1, it writes the shifted value unchanged.
- R4: Every accumulator write updates the flags from the value written: negative = bit 35, zero = all 36 bits zero, arithmetic overflow = the R3 overflow of a product load, logical overflow = shifted value not representable in 36 bits (never true for a 32-bit product). Arithmetic and logical overflow are 0 after an upper-half load. Without a write the flags hold.
- R5: Each accumulator has a sticky overflow bit. An overflowing product load into that accumulator sets it, a status-word write clears it, and a set in the same cycle as the clear wins.
- R6: The status word reads {negative, zero, logical ovf, arithmetic ovf, 2'b00, acc1 sticky, acc1[35:32], acc0 sticky, acc0[35:32]}, from bit 15 down to bit 0. Reset clears all flags, sticky bits and accumulators.
- R7: An upper-half load writes `hi_data` to bits 31:16 of the selected accumulator, with its sign copied into bits 35:32. Bits 15:0 become zero when that accumulator's low-keep bit is 0, and keep their value when it is 1.
- R8: A `y` high write zeroes `y` bits 15:0 unless the y low-keep bit is set. A same-cycle low write supplies the low half instead. When the square-mode bit is set, a `y` high write also writes the same value into `x`. Otherwise `x` keeps its value.
- R9: A product load takes priority over a same-cycle upper-half load. The accumulator not selected is unchanged. A load uses the control value held before the edge, not one written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control register readback |
| ld_en | input | 1 | Product load request |
| ld_sel | input | 1 | Product load destination (0 = acc0, 1 = acc1) |
| prod | input | 32 | Product, two's complement |
| hi_en | input | 1 | Upper-half load request |
| hi_sel | input | 1 | Upper-half load destination |
| hi_data | input | 16 | Upper-half data |
| y_hi_we | input | 1 | Write `y` bits 31:16 |
| y_hi_data | input | 16 | `y` high data |
| y_lo_we | input | 1 | Write `y` bits 15:0 |
| y_lo_data | input | 16 | `y` low data |
| psw_we | input | 1 | Status word write, clears sticky bits |
| psw_rdata | output | 16 | Status word readback |
| acc0 | output | 36 | Accumulator 0 |
| acc1 | output | 36 | Accumulator 1 |
| x_q | output | 16 | `x` register |
| y_q | output | 32 | `y` register |

## Verification
Every result here comes from a single register stage. An accumulator, flag, sticky bit, `x`/`y` or control change requested before a rising edge is visible on the outputs right after that edge and never earlier. The bench drives each request on a falling edge. It removes the request on the next falling edge, after the capturing rising edge has passed, and samples the outputs at that same falling edge. Same-cycle cases (control write beside a load, clear beside an overflow, product load beside an upper-half load) are driven together in one cycle so the precedence is seen in that single update.

// File: rtl/dau_acc_unit.sv
`timescale 1ns/1ps
module dau_acc_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [15:0] ctl_wdata,
  output logic [15:0] ctl_rdata,
  input  logic        ld_en,
  input  logic        ld_sel,
  input  logic [31:0] prod,
  input  logic        hi_en,
  input  logic        hi_sel,
  input  logic [15:0] hi_data,
  input  logic        y_hi_we,
  input  logic [15:0] y_hi_data,
  input  logic        y_lo_we,
  input  logic [15:0] y_lo_data,
  input  logic        psw_we,
  output logic [15:0] psw_rdata,
  output logic [35:0] acc0,
  output logic [35:0] acc1,
  output logic [15:0] x_q,
  output logic [31:0] y_q
);
  localparam logic [35:0] SAT_POS = 36'h0_7FFF_FFFF;
  localparam logic [35:0] SAT_NEG = 36'hF_8000_0000;

  logic [8:0]  ctl;
  logic [37:0] pext, shifted;
  logic        mov, lov, clamp_off, keep_lo, wr_en, wr_sel;
  logic [35:0] ld_val, hi_val, wr_val, hi_old;
  logic        f_neg, f_zero, f_lov, f_mov, ov0, ov1;

  assign ctl_rdata = {7'd0, ctl};
  assign pext      = {{6{prod[31]}}, prod};

  always_comb begin
    case (ctl[1:0])
      2'b00:   shifted = pext;
      2'b01:   shifted = {{2{pext[37]}}, pext[37:2]};
      2'b10:   shifted = {pext[35:0], 2'b00};
      default: shifted = {pext[36:0], 1'b0};
    endcase
  end

  assign mov       = ~(&shifted[35:31] | ~|shifted[35:31]);
  assign lov       = ~(&shifted[37:35] | ~|shifted[37:35]);
  assign clamp_off = ld_sel ? ctl[3] : ctl[2];
  assign ld_val    = (mov && !clamp_off) ? (prod[31] ? SAT_NEG : SAT_POS) : shifted[35:0];

  assign hi_old  = hi_sel ? acc1 : acc0;
  assign keep_lo = hi_sel ? ctl[5] : ctl[4];
  assign hi_val  = {{4{hi_data[15]}}, hi_data, keep_lo ? hi_old[15:0] : 16'h0000};

  assign wr_en  = ld_en | hi_en;
  assign wr_sel = ld_en ? ld_sel : hi_sel;
  assign wr_val = ld_en ? ld_val : hi_val;

  assign psw_rdata = {f_neg, f_zero, f_lov, f_mov, 2'b00, ov1, acc1[35:32], ov0, acc0[35:32]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (ctl_we) begin
      ctl <= ctl_wdata[8:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0   <= '0;
      acc1   <= '0;
      f_neg  <= 1'b0;
      f_zero <= 1'b0;
      f_lov  <= 1'b0;
      f_mov  <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel) acc1 <= wr_val;
      else        acc0 <= wr_val;
      f_neg  <= wr_val[35];
      f_zero <= (wr_val == 36'd0);
      f_lov  <= ld_en & lov;
      f_mov  <= ld_en & mov;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov0 <= 1'b0;
      ov1 <= 1'b0;
    end else begin
      if (ld_en && !ld_sel && mov) ov0 <= 1'b1;
      else if (psw_we)             ov0 <= 1'b0;
      if (ld_en && ld_sel && mov)  ov1 <= 1'b1;
      else if (psw_we)             ov1 <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
      x_q <= '0;
    end else begin
      if (y_hi_we) begin
        y_q[31:16] <= y_hi_data;
        if (ctl[7]) x_q <= y_hi_data;
      end
      if (y_lo_we)                  y_q[15:0] <= y_lo_data;
      else if (y_hi_we && !ctl[6])  y_q[15:0] <= 16'h0000;
    end
  end

  // R3
  sat_a0_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !ld_sel && !ctl[2]) |=> (&acc0[35:31] || ~|acc0[35:31]));

  // R3
  sat_a1_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel && !ctl[3]) |=> (&acc1[35:31] || ~|acc1[35:31]));

  // R4
  flag_a0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !ld_sel) |=> (psw_rdata[15] == acc0[35] && psw_rdata[14] == (acc0 == 36'd0)));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_rdata[4] && !psw_we) |=> psw_rdata[4]);

  // R7
  hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en && !ld_en && !hi_sel && !ctl[4]) |=> (acc0[15:0] == 16'h0000));

  // R8
  square_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_hi_we && ctl[7]) |=> (x_q == y_q[31:16]));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !hi_en) |=> ($stable(acc0) && $stable(acc1)));
endmodule

// File: tb/tb_dau_acc_unit.sv
`timescale 1ns/1ps
module tb_dau_acc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 0, ld_en = 0, ld_sel = 0, hi_en = 0, hi_sel = 0;
  logic        y_hi_we = 0, y_lo_we = 0, psw_we = 0;
  logic [15:0] ctl_wdata = 0, hi_data = 0, y_hi_data = 0, y_lo_data = 0;
  logic [31:0] prod = 0;
  logic [15:0] ctl_rdata, psw_rdata, x_q;
  logic [35:0] acc0, acc1;
  logic [31:0] y_q;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dau_acc_unit dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ld_en(ld_en), .ld_sel(ld_sel), .prod(prod), .hi_en(hi_en), .hi_sel(hi_sel),
    .hi_data(hi_data), .y_hi_we(y_hi_we), .y_hi_data(y_hi_data), .y_lo_we(y_lo_we),
    .y_lo_data(y_lo_data), .psw_we(psw_we), .psw_rdata(psw_rdata), .acc0(acc0),
    .acc1(acc1), .x_q(x_q), .y_q(y_q));

  // {ctl[8:0], sel, prod[31:0], expected acc[35:0], flags {neg,zero,lov,mov}, sticky}
  localparam int NV = 13;
  localparam logic [82:0] VEC [NV] = '{
    {9'h000, 1'b0, 32'h1234_5678, 36'h0_1234_5678, 4'b0000, 1'b0},
    {9'h001, 1'b1, 32'hFFFF_FFFD, 36'hF_FFFF_FFFF, 4'b1000, 1'b0},
    {9'h002, 1'b0, 32'h0000_0003, 36'h0_0000_000C, 4'b0000, 1'b0},
    {9'h003, 1'b1, 32'h0000_0005, 36'h0_0000_000A, 4'b0000, 1'b0},
    {9'h003, 1'b0, 32'h4000_0000, 36'h0_7FFF_FFFF, 4'b0001, 1'b1},
    {9'h007, 1'b0, 32'h4000_0000, 36'h0_8000_0000, 4'b0001, 1'b1},
    {9'h002, 1'b1, 32'h8000_0000, 36'hF_8000_0000, 4'b1001, 1'b1},
    {9'h00A, 1'b1, 32'h8000_0000, 36'hE_0000_0000, 4'b1001, 1'b1},
    {9'h001, 1'b0, 32'h0000_0003, 36'h0_0000_0000, 4'b0100, 1'b0},
    {9'h000, 1'b1, 32'h0000_0000, 36'h0_0000_0000, 4'b0100, 1'b0},
    {9'h002, 1'b0, 32'h2000_0000, 36'h0_7FFF_FFFF, 4'b0001, 1'b1},
    {9'h00B, 1'b0, 32'hC000_0000, 36'hF_8000_0000, 4'b1000, 1'b0},
    {9'h001, 1'b1, 32'h8000_0000, 36'hF_E000_0000, 4'b1000, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    ctl_we = 0; ld_en = 0; hi_en = 0; y_hi_we = 0; y_lo_we = 0; psw_we = 0;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    ctl_we = 1; ctl_wdata = v; tick();
  endtask

  task automatic load(input logic s, input logic [31:0] p);
    ld_en = 1; ld_sel = s; prod = p; tick();
  endtask

  task automatic hiload(input logic s, input logic [15:0] d);
    hi_en = 1; hi_sel = s; hi_data = d; tick();
  endtask

  task automatic clr_psw;
    psw_we = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [35:0] keep1;
    repeat (3) @(negedge clk);
    chk("R1 reset ctl", ctl_rdata, 0);
    chk("R6 reset psw", psw_rdata, 0);
    chk("R6 reset acc0", acc0, 0);
    chk("R6 reset acc1", acc1, 0);
    chk("R8 reset y", y_q, 0);
    rst_n = 1;
    @(negedge clk);

    wr_ctl(16'hFFFF);
    chk("R1 upper bits read zero", ctl_rdata, 16'h01FF);

    for (int i = 0; i < NV; i++) begin
      wr_ctl({7'd0, VEC[i][82:74]});
      keep1 = VEC[i][73] ? acc0 : acc1;
      load(VEC[i][73], VEC[i][72:41]);
      chk($sformatf("R2/R3 vec %0d acc", i), VEC[i][73] ? acc1 : acc0, VEC[i][40:5]);
      chk($sformatf("R4 vec %0d flags", i), psw_rdata[15:12], VEC[i][4:1]);
      chk($sformatf("R5 vec %0d sticky", i), VEC[i][73] ? psw_rdata[9] : psw_rdata[4], VEC[i][0]);
      chk($sformatf("R9 vec %0d other acc", i), VEC[i][73] ? acc0 : acc1, keep1);
      clr_psw();
    end

    // R5 sticky behaviour
    wr_ctl(16'h0003);
    load(0, 32'h4000_0000);
    load(0, 32'h0000_0001);
    chk("R5 sticky holds", psw_rdata[4], 1);
    chk("R4 mov follows last load", psw_rdata[12], 0);
    clr_psw();
    chk("R5 cleared by psw write", psw_rdata[4], 0);
    ld_en = 1; ld_sel = 0; prod = 32'h4000_0000; psw_we = 1; tick();
    chk("R5 set wins over clear", psw_rdata[4], 1);
    chk("R5 acc1 sticky untouched", psw_rdata[9], 0);

    // R6 layout
    wr_ctl(16'h0000);
    load(1, 32'h8000_0000);
    chk("R6 status layout", psw_rdata, 16'h81F0);
    clr_psw();

    // R9 control written same cycle is not used
    ctl_we = 1; ctl_wdata = 16'h0003; ld_en = 1; ld_sel = 0; prod = 32'h0000_0005; tick();
    chk("R9 old control used", acc0, 36'h5);
    chk("R1 control stored", ctl_rdata, 16'h0003);

    // R9 product load beats upper-half load
    ld_en = 1; ld_sel = 0; prod = 32'h0000_0001; hi_en = 1; hi_sel = 0; hi_data = 16'h7777; tick();
    chk("R9 product load wins", acc0, 36'h2);

    // R7 upper-half loads
    wr_ctl(16'h0000);
    load(0, 32'h0000_ABCD);
    hiload(0, 16'h8001);
    chk("R7 acc0 low cleared", acc0, 36'hF_8001_0000);
    chk("R4 flags after hi load", psw_rdata[15:12], 4'b1000);
    load(0, 32'h0000_ABCD);
    wr_ctl(16'h0010);
    hiload(0, 16'h7FFF);
    chk("R7 acc0 low kept", acc0, 36'h0_7FFF_ABCD);
    wr_ctl(16'h0020);
    load(1, 32'h0000_1111);
    hiload(1, 16'h0000);
    chk("R7 acc1 low kept", acc1, 36'h0_0000_1111);
    chk("R4 zero flag clear", psw_rdata[14], 0);
    wr_ctl(16'h0010);
    load(1, 32'h0000_1111);
    hiload(1, 16'h0000);
    chk("R7 acc1 low cleared", acc1, 36'h0);
    chk("R4 zero after hi load", psw_rdata[15:12], 4'b0100);

    // R8 y and x
    wr_ctl(16'h0000);
    y_lo_we = 1; y_lo_data = 16'h5555; tick();
    y_hi_we = 1; y_hi_data = 16'h1234; tick();
    chk("R8 y low cleared", y_q, 32'h1234_0000);
    chk("R8 x untouched", x_q, 16'h0000);
    wr_ctl(16'h0040);
    y_lo_we = 1; y_lo_data = 16'h5555; tick();
    y_hi_we = 1; y_hi_data = 16'hAAAA; tick();
    chk("R8 y low kept", y_q, 32'hAAAA_5555);
    wr_ctl(16'h0080);
    y_hi_we = 1; y_hi_data = 16'h0F0F; tick();
    chk("R8 square mode x", x_q, 16'h0F0F);
    chk("R8 square mode y", y_q, 32'h0F0F_0000);
    y_hi_we = 1; y_hi_data = 16'h2222; y_lo_we = 1; y_lo_data = 16'h3333; tick();
    chk("R8 low write beats clear", y_q, 32'h2222_3333);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule